// File: doc/BRIEF.md
# Buffered PWM Channel Pair

This block joins two neighbouring timer channels so that one PWM pin is driven from two compare registers. It takes the count and a wrap pulse from a shared timebase, plus a byte-wide register write bus. In unlinked operation the even channel is an ordinary output-compare channel: a counter match applies an edge action to the pin, and the pin may also toggle at every wrap. That is enough for an unbuffered PWM.

When the link bit is set, the two compare registers work as a pair. One is active. Software may write the other at any time. The hardware makes the newly written register active only at the next counter wrap, so a duty-cycle change never cuts a period short, even when the jump is large. While linked, the odd channel's pin is released to general-purpose port logic.

Each 16-bit compare value is written as two bytes. The high byte is staged. The value takes effect when the low byte arrives.

Top module: `pwm_pair_buf`

## Requirements
- R1: After reset, `pwm_o`, `flag_o`, `irq_o` and `odd_gpio_o` are all 0.
- R2: Writing a high byte (address 1 for the even register, address 3 for the odd one) only stages that byte. The compare value in use changes only when the low byte is written (address 2 even, address 4 odd). The committed value is {staged byte, low byte}.
- R3: The control register is at address 0. Its fields are:
  - bit 7 = flag write
  - bit 6 = interrupt enable
  - bit 5 = link
  - bit 4 = compare enable
  - bits 3:2 = match action (00 none, 01 toggle, 10 clear, 11 set)
  - bit 1 = toggle on wrap

  With compare enable, action 10 and toggle on wrap, a compare value C gives C high cycles in each period, starting at the wrap.
- R4: With the link bit set, `odd_gpio_o` is 1 from the cycle after the write, and buffered operation applies whatever bit 4 holds. While unlinked, writes to the odd compare register leave the output unchanged.
- R5: While linked, committing a value to the inactive register makes that register active at the next wrap. The period in progress keeps the old width.
- R6: If both registers are committed within one period, the one committed last is active after the wrap. A commit to the active register takes effect at once.
- R7: When a wrap and a compare match fall in the same cycle with toggle on wrap enabled, the toggle wins over the match action.
- R8: A compare value above the highest count never matches. It sets no flag and applies no action.
- R9: A match on the active register sets `flag_o`. `irq_o` is `flag_o` AND the interrupt enable. A control write with bit 7 = 0 clears the flag unless a match occurs in the same cycle.
- R10: Match action 11 sets the pin and action 01 toggles it. With toggle on wrap and action 11, the pin is low for C cycles after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_i | input | CW | Shared timebase count |
| ovf_i | input | 1 | Wrap pulse, high in the cycle the count shows 0 after a wrap |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register address |
| wr_data_i | input | DW | Register write data |
| pwm_o | output | 1 | Even channel pin (PWM output) |
| odd_gpio_o | output | 1 | 1 when the odd pin is released to port logic |
| flag_o | output | 1 | Compare flag of the active register |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume a timebase that moves the count by at most one per cycle and raises `ovf_i` only in the cycle when the count has just returned to 0. The wrap-toggle and selection checks rely on this. The bench builds its own timebase with exactly that shape and a period of 256 counts. It issues register writes a few cycles after a wrap, so that a commit never lands in the same cycle as a wrap or as a match at the old compare value. A queue of expected high-cycle counts per period is compared with what the pin actually does.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE   = 2'b00,
    EDGE_TOGGLE = 2'b01,
    EDGE_CLEAR  = 2'b10,
    EDGE_SET    = 2'b11
  } edge_act_e;

  // control byte bits 6:1; bit 7 is the flag write, bit 0 reserved
  typedef struct packed {
    logic      ie;
    logic      link;
    logic      cmp_en;
    edge_act_e edge_act;
    logic      tov;
  } ctrl_t;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CMP0 = 1;  // slot s: high at 1+2s, low at 2+2s
  localparam int unsigned SLOTS     = 2;

endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
  import pwm_pair_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  output ctrl_t                      ctrl_o,
  output logic [SLOTS-1:0][CW-1:0]   cmp_o,
  output logic [SLOTS-1:0]           commit_o,
  output logic                       flag_clr_o
);
  localparam int HW = CW - DW;  // staged high part, 1..DW bits

  logic ctrl_hit;
  assign ctrl_hit   = wr_en_i && (wr_addr_i == AW'(ADDR_CTRL));
  assign flag_clr_o = ctrl_hit && !wr_data_i[DW-1];

  always_ff @(posedge clk_i) begin
    if (rst_i) ctrl_o <= '0;
    else if (ctrl_hit) ctrl_o <= ctrl_t'(wr_data_i[6:1]);
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [HW-1:0] stage_q;
    logic          hi_hit, lo_hit;
    assign hi_hit = wr_en_i && (wr_addr_i == AW'(ADDR_CMP0 + 2*s));
    assign lo_hit = wr_en_i && (wr_addr_i == AW'(ADDR_CMP0 + 2*s + 1));
    assign commit_o[s] = lo_hit;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        stage_q  <= '0;
        cmp_o[s] <= '1;
      end else begin
        if (hi_hit) stage_q <= wr_data_i[HW-1:0];
        if (lo_hit) cmp_o[s] <= {stage_q, wr_data_i};
      end
    end
  end

endmodule

// File: rtl/pwm_pair_select.sv
module pwm_pair_select
  import pwm_pair_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             link_i,
  input  logic             ovf_i,
  input  logic [SLOTS-1:0] commit_i,
  output logic             act_o
);
  logic next_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !link_i) begin
      next_q <= 1'b0;
      act_o  <= 1'b0;
    end else begin
      // the most recent commit names the register for the next period
      if (commit_i[1])      next_q <= 1'b1;
      else if (commit_i[0]) next_q <= 1'b0;
      if (ovf_i) act_o <= next_q;
    end
  end

endmodule

// File: rtl/pwm_pair_wave.sv
module pwm_pair_wave
  import pwm_pair_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          ovf_i,
  input  ctrl_t         ctrl_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          flag_clr_i,
  output logic          pwm_o,
  output logic          flag_o,
  output logic          irq_o
);
  logic en, hit, pwm_d, flag_d;

  always_comb begin
    en    = ctrl_i.link | ctrl_i.cmp_en;
    hit   = en && (cnt_i == cmp_i);
    pwm_d = pwm_o;
    if (!en) begin
      pwm_d = 1'b0;
    end else if (ovf_i && ctrl_i.tov) begin
      pwm_d = ~pwm_o;  // wrap toggle beats a same-cycle match
    end else if (hit) begin
      case (ctrl_i.edge_act)
        EDGE_TOGGLE: pwm_d = ~pwm_o;
        EDGE_CLEAR:  pwm_d = 1'b0;
        EDGE_SET:    pwm_d = 1'b1;
        default:     pwm_d = pwm_o;
      endcase
    end
    flag_d = flag_o;
    if (hit) flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pwm_o  <= 1'b0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      pwm_o  <= pwm_d;
      flag_o <= flag_d;
      irq_o  <= flag_d & ctrl_i.ie;
    end
  end

endmodule

// File: rtl/pwm_pair_buf.sv
module pwm_pair_buf
  import pwm_pair_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          ovf_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          pwm_o,
  output logic          odd_gpio_o,
  output logic          flag_o,
  output logic          irq_o
);
  ctrl_t                    ctrl;
  logic [SLOTS-1:0][CW-1:0] cmp;
  logic [SLOTS-1:0]         commit;
  logic                     flag_clr;
  logic                     act;
  logic [CW-1:0]            cmp_act, cmp_even;
  logic                     en;

  pwm_pair_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ctrl_o(ctrl), .cmp_o(cmp), .commit_o(commit),
    .flag_clr_o(flag_clr)
  );

  pwm_pair_select u_sel (
    .clk_i(clk_i), .rst_i(rst_i), .link_i(ctrl.link), .ovf_i(ovf_i),
    .commit_i(commit), .act_o(act)
  );

  assign cmp_act    = cmp[act];
  assign cmp_even   = cmp[0];
  assign en         = ctrl.link | ctrl.cmp_en;
  assign odd_gpio_o = ctrl.link;

  pwm_pair_wave #(.CW(CW)) u_wave (
    .clk_i(clk_i), .rst_i(rst_i), .cnt_i(cnt_i), .ovf_i(ovf_i), .ctrl_i(ctrl),
    .cmp_i(cmp_act), .flag_clr_i(flag_clr), .pwm_o(pwm_o), .flag_o(flag_o),
    .irq_o(irq_o)
  );

endmodule

// File: rtl/pwm_pair_buf_chk.sv
module pwm_pair_buf_chk
  import pwm_pair_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic [CW-1:0] cnt_i,
  input logic          ovf_i,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          pwm_o,
  input logic          odd_gpio_o,
  input logic          flag_o,
  input logic          irq_o,
  input logic          link_i,
  input logic          tov_i,
  input logic          en_i,
  input logic          act_i,
  input logic [CW-1:0] cmp_act_i,
  input logic [CW-1:0] cmp_even_i
);
  a_r4_link_frees_odd: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == AW'(ADDR_CTRL)) |=> (odd_gpio_o == $past(wr_data_i[5])));

  a_r2_high_byte_stages: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == AW'(ADDR_CMP0)) |=> $stable(cmp_even_i));

  a_r5_switch_only_at_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ovf_i && link_i) |=> $stable(act_i));

  a_r7_wrap_toggle_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovf_i && tov_i && en_i) |=> (pwm_o != $past(pwm_o)));

  a_r8_flag_needs_match: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(flag_o) |-> $past(en_i && (cnt_i == cmp_act_i)));

  a_r9_irq_implies_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> flag_o);

endmodule

bind pwm_pair_buf pwm_pair_buf_chk #(.CW(CW), .DW(DW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .cnt_i(cnt_i), .ovf_i(ovf_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .pwm_o(pwm_o),
  .odd_gpio_o(odd_gpio_o), .flag_o(flag_o), .irq_o(irq_o), .link_i(ctrl.link),
  .tov_i(ctrl.tov), .en_i(en), .act_i(act), .cmp_act_i(cmp_act),
  .cmp_even_i(cmp_even)
);

// File: tb/pwm_pair_buf_bench.sv
module pwm_pair_buf_bench;
  localparam int CW = 16;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int TOP = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [CW-1:0] cnt = '0;
  logic          ovf = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          pwm, odd_gpio, flag, irq;

  pwm_pair_buf #(.CW(CW), .DW(DW), .AW(AW)) u_pwm_pair_buf (
    .clk_i(clk), .rst_i(rst), .cnt_i(cnt), .ovf_i(ovf), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pwm),
    .odd_gpio_o(odd_gpio), .flag_o(flag), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // timebase: count 0..TOP, wrap pulse while the count shows 0 after a wrap
  always @(negedge clk) begin
    if (!rst) begin
      cnt <= (cnt == CW'(TOP)) ? '0 : cnt + 1'b1;
      ovf <= (cnt == CW'(TOP));
    end
  end

  // scoreboard: expected high-cycle counts per period
  typedef struct {
    int    w;
    string tag;
  } exp_t;
  exp_t q[$];
  event wrap_ev;
  int   hi_cnt = 0;
  bit   win_ok = 0;
  logic wrap_pwm = 1'b0;

  task automatic expect_w(int w, string tag);
    exp_t e;
    e.w = w;
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (ovf) begin
        if (win_ok && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          chk(hi_cnt == e.w, e.tag, hi_cnt, e.w);
        end
        hi_cnt   = pwm ? 1 : 0;
        win_ok   = 1;
        wrap_pwm = pwm;
        -> wrap_ev;
      end else if (win_ok) begin
        hi_cnt += pwm ? 1 : 0;
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(a);
    wr_data = DW'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wr16(int hi_addr, int v);
    wr(hi_addr, (v >> 8) & 255);
    wr(hi_addr + 1, v & 255);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm == 1'b0, "R1 pwm", int'(pwm), 0);
    chk(flag == 1'b0, "R1 flag", int'(flag), 0);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(odd_gpio == 1'b0, "R1 odd_gpio", int'(odd_gpio), 0);

    // R3 unbuffered clear-on-match with wrap toggle; R4 odd writes ignored
    wr16(1, 'h00C0);
    wr(0, 'h1A);
    wr16(3, 'h0010);
    chk(odd_gpio == 1'b0, "R4 unlinked odd pin", int'(odd_gpio), 0);
    @(wrap_ev);
    expect_w(192, "R3 width 192");
    expect_w(192, "R4 odd write no effect");
    repeat (2) @(wrap_ev);

    // R2 high byte alone stays staged
    wr(1, 'h01);
    @(wrap_ev);
    expect_w(192, "R2 staged high byte");
    expect_w(192, "R2 staged high byte");
    repeat (2) @(wrap_ev);

    // R8 commit 0x0140, above top: no match, only wrap toggles
    wr(2, 'h40);
    wr(0, 'h1A);
    @(wrap_ev);
    expect_w(0, "R8 no match low period");
    expect_w(256, "R8 no match high period");
    repeat (2) @(wrap_ev);
    chk(flag == 1'b0, "R8 flag stays clear", int'(flag), 0);

    // R9 flag, interrupt, clear
    wr16(1, 'h00C0);
    wr(0, 'h5A);
    @(wrap_ev);
    repeat (200) @(negedge clk);
    chk(flag == 1'b1, "R9 flag set", int'(flag), 1);
    chk(irq == 1'b1, "R9 irq set", int'(irq), 1);
    wr(0, 'h5A);
    chk(flag == 1'b0, "R9 flag cleared", int'(flag), 0);
    chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
    wr(0, 'h1A);
    @(wrap_ev);
    repeat (200) @(negedge clk);
    chk(flag == 1'b1, "R9 flag set ie off", int'(flag), 1);
    chk(irq == 1'b0, "R9 irq masked", int'(irq), 0);

    // R10 set action with wrap toggle
    @(wrap_ev);
    wr(0, 'h1E);
    @(wrap_ev);
    expect_w(64, "R10 set action");
    expect_w(64, "R10 set action");
    repeat (2) @(wrap_ev);

    // R10 toggle action, no wrap toggle
    wr(0, 'h14);
    @(wrap_ev);
    expect_w(192, "R10 toggle action");
    expect_w(64, "R10 toggle action");
    repeat (2) @(wrap_ev);

    // R7 compare 0 collides with wrap: toggle wins
    wr16(1, 'h0000);
    wr(0, 'h1A);
    @(wrap_ev);
    expect_w(wrap_pwm ? 256 : 0, "R7 wrap toggle precedence");
    expect_w(wrap_pwm ? 0 : 256, "R7 wrap toggle precedence");
    repeat (2) @(wrap_ev);

    // R4 link with compare-enable bit also set
    wr16(1, 'h00C0);
    wr(0, 'h3A);
    chk(odd_gpio == 1'b1, "R4 linked odd pin", int'(odd_gpio), 1);
    @(wrap_ev);
    expect_w(192, "R4 linked even width");
    @(wrap_ev);

    // R5 inactive register switches at the next wrap
    expect_w(192, "R5 old width kept");
    wr16(3, 'h00FE);
    expect_w(254, "R5 new width after wrap");
    expect_w(254, "R5 new width after wrap");
    repeat (3) @(wrap_ev);

    // R6 odd active: write odd, then even last
    wr16(3, 'h0080);
    wr16(1, 'h0040);
    expect_w(128, "R6 active write immediate");
    expect_w(64, "R6 last written wins");
    repeat (2) @(wrap_ev);

    // R6 even active: write odd then even
    wr16(3, 'h00A0);
    wr16(1, 'h0030);
    expect_w(48, "R6 active write immediate");
    expect_w(48, "R6 pending odd cancelled");
    repeat (2) @(wrap_ev);

    chk(q.size() == 0, "R5 scoreboard drained", q.size(), 0);
    summary();
    $finish;
  end

endmodule